// File: doc/BRIEF.md
# Segment Table Address Translator

The block turns a segmented virtual address into a physical address. The upper bits of the virtual address select one entry of a small table held inside the block. Each entry stores a valid flag, a base address, a size limit and three permission bits. The lower bits form an offset. The offset is checked against the limit, and the access kind is checked against the permissions. If both checks pass, the physical address is the base plus the offset.

Software or a control agent fills the table through a write-only configuration port, one entry per cycle. Lookups use a valid/ready handshake. Every accepted lookup produces exactly one registered response on the next cycle. The response carries either a physical address or a two-bit fault cause, which lets the requester tell an unmapped segment from an overrun and from a forbidden access.

Top module: `seg_xlat`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every table entry reads as invalid and `rsp_valid` is 0. `req_ready` is 0 during reset and 1 at all other times.
- R2: The segment number is the top `$clog2(SEG_COUNT)` bits of `req_vaddr`. The offset is the low `OFF_W` bits. The segment number selects the table entry directly.
- R3: A permitted, in-bounds lookup on a valid entry returns fault code 2'b00 with `rsp_paddr` = base + offset, modulo 2^BASE_W.
- R4: An offset greater than or equal to the entry limit returns fault 2'b01 with `rsp_paddr` = 0. A limit of 0 rejects every offset, and a limit of 2^OFF_W admits every offset.
- R5: The access kind is encoded 2'b00 fetch, 2'b01 load, 2'b10 store. The permission bits are: bit 0 allows fetch, bit 1 allows load, bit 2 allows store. A kind whose bit is clear returns fault 2'b10 with `rsp_paddr` = 0. For example, an entry with permissions 3'b011 (a code segment) rejects stores. Kind 2'b11 always returns fault 2'b10.
- R6: A lookup on an invalid entry returns fault 2'b11 with `rsp_paddr` = 0.
- R7: When several faults apply, the reported cause follows this priority: invalid segment first, then bounds, then permission.
- R8: `rsp_valid` is 1 exactly on the cycle after a cycle in which `req_valid` and `req_ready` were both 1. On any other cycle, `rsp_fault` and `rsp_paddr` are 0.
- R9: When a table write and a lookup address the same entry in the same cycle, the lookup uses the entry contents from before the write.
- R10: A table write with `cfg_valid` = 0 makes the entry invalid. Later lookups to that entry fault with 2'b11 until the entry is written again with `cfg_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | $clog2(SEG_COUNT) | Entry to write |
| cfg_valid | input | 1 | Valid flag to store in the entry |
| cfg_base | input | BASE_W | Base address to store |
| cfg_limit | input | OFF_W+1 | Segment size in bytes |
| cfg_perm | input | 3 | Permissions: bit 0 fetch, bit 1 load, bit 2 store |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_vaddr | input | $clog2(SEG_COUNT)+OFF_W | Virtual address: segment number over offset |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | BASE_W | Physical address, 0 on a fault |
| rsp_fault | output | 2 | Fault cause |

## Verification
The bench builds the block with its defaults: 8 segments, a 16-bit offset and a 32-bit base. With only eight entries, random traffic revisits each entry many times after it has been rewritten, invalidated or had its permissions changed. The 17-bit limit lets the bench reach both bound extremes directly: a limit of 0 rejects offset 0, and a limit of 65536 admits offset 0xFFFF. Bases near the top of the 32-bit range make base-plus-offset wrap, which checks the modulo rule.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_BOUNDS = 2'b01,
        FLT_PERM   = 2'b10,
        FLT_NOSEG  = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    localparam int PERM_W     = 3;
    localparam int PERM_FETCH = 0;
    localparam int PERM_LOAD  = 1;
    localparam int PERM_STORE = 2;

    function automatic logic kind_allowed(input logic [PERM_W-1:0] perm,
                                          input logic [1:0] kind);
        logic ok;
        case (kind)
            ACC_FETCH: ok = perm[PERM_FETCH];
            ACC_LOAD:  ok = perm[PERM_LOAD];
            ACC_STORE: ok = perm[PERM_STORE];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlat_pkg::*;
#(
    parameter int SEG_COUNT = 8,
    parameter int OFF_W     = 16,
    parameter int BASE_W    = 32,
    localparam int SEG_W    = $clog2(SEG_COUNT),
    localparam int LIM_W    = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic [PERM_W-1:0] rd_perm
);

    logic              ent_valid [SEG_COUNT];
    logic [BASE_W-1:0] ent_base  [SEG_COUNT];
    logic [LIM_W-1:0]  ent_limit [SEG_COUNT];
    logic [PERM_W-1:0] ent_perm  [SEG_COUNT];

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
        logic hit_wr;
        assign hit_wr = wr_en && (wr_idx == SEG_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[g] <= 1'b0;
                ent_base[g]  <= '0;
                ent_limit[g] <= '0;
                ent_perm[g]  <= '0;
            end else if (hit_wr) begin
                ent_valid[g] <= wr_valid;
                ent_base[g]  <= wr_base;
                ent_limit[g] <= wr_limit;
                ent_perm[g]  <= wr_perm;
            end
        end
    end

    // Combinational read of the registered entry: a same-cycle write lands after this read
    always_comb begin
        rd_valid = ent_valid[rd_idx];
        rd_base  = ent_base[rd_idx];
        rd_limit = ent_limit[rd_idx];
        rd_perm  = ent_perm[rd_idx];
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int BASE_W = 32,
    localparam int LIM_W = OFF_W + 1
) (
    input  logic              ent_valid,
    input  logic [BASE_W-1:0] ent_base,
    input  logic [LIM_W-1:0]  ent_limit,
    input  logic [PERM_W-1:0] ent_perm,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        kind,
    output fault_e            fault,
    output logic [BASE_W-1:0] paddr
);

    logic in_bounds;
    assign in_bounds = {1'b0, offset} < ent_limit;

    always_comb begin
        paddr = '0;
        if (!ent_valid) begin
            fault = FLT_NOSEG;
        end else if (!in_bounds) begin
            fault = FLT_BOUNDS;
        end else if (!kind_allowed(ent_perm, kind)) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
            paddr = ent_base + BASE_W'(offset);
        end
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int SEG_COUNT = 8,
    parameter int OFF_W     = 16,
    parameter int BASE_W    = 32,
    localparam int SEG_W    = $clog2(SEG_COUNT),
    localparam int LIM_W    = OFF_W + 1,
    localparam int VA_W     = SEG_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic [2:0]        cfg_perm,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic [BASE_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault
);

    logic [SEG_W-1:0]  seg_num;
    logic [OFF_W-1:0]  offset;
    logic              t_valid;
    logic [BASE_W-1:0] t_base;
    logic [LIM_W-1:0]  t_limit;
    logic [PERM_W-1:0] t_perm;
    fault_e            c_fault;
    logic [BASE_W-1:0] c_paddr;
    logic              accept;

    assign seg_num   = req_vaddr[VA_W-1 -: SEG_W];
    assign offset    = req_vaddr[OFF_W-1:0];
    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;

    seg_table #(
        .SEG_COUNT (SEG_COUNT),
        .OFF_W     (OFF_W),
        .BASE_W    (BASE_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_valid (cfg_valid),
        .wr_base  (cfg_base),
        .wr_limit (cfg_limit),
        .wr_perm  (cfg_perm),
        .rd_idx   (seg_num),
        .rd_valid (t_valid),
        .rd_base  (t_base),
        .rd_limit (t_limit),
        .rd_perm  (t_perm)
    );

    seg_check #(
        .OFF_W  (OFF_W),
        .BASE_W (BASE_W)
    ) u_check (
        .ent_valid (t_valid),
        .ent_base  (t_base),
        .ent_limit (t_limit),
        .ent_perm  (t_perm),
        .offset    (offset),
        .kind      (req_kind),
        .fault     (c_fault),
        .paddr     (c_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= accept;
            rsp_paddr <= accept ? c_paddr : '0;
            rsp_fault <= accept ? c_fault : FLT_NONE;
        end
    end

endmodule

// File: rtl/seg_xlat_sva.sv
module seg_xlat_sva #(
    parameter int BASE_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic              rsp_valid,
    input logic [BASE_W-1:0] rsp_paddr,
    input logic [1:0]        rsp_fault
);

    // R8
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && req_ready));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_fault == 2'b00 && rsp_paddr == '0));

    // R4
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);

    // R5
    rsvd_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_kind) == 2'b11) |-> rsp_fault != 2'b00);

    // R1
    ready_out_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready);

endmodule

bind seg_xlat seg_xlat_sva #(.BASE_W(BASE_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/tb_seg_xlat.sv
module tb_seg_xlat;

    localparam int CLK_PERIOD = 10;
    localparam int SEG_COUNT  = 8;
    localparam int OFF_W      = 16;
    localparam int BASE_W     = 32;
    localparam int SEG_W      = $clog2(SEG_COUNT);
    localparam int LIM_W      = OFF_W + 1;
    localparam int VA_W       = SEG_W + OFF_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_we;
    logic [SEG_W-1:0]  cfg_idx;
    logic              cfg_valid;
    logic [BASE_W-1:0] cfg_base;
    logic [LIM_W-1:0]  cfg_limit;
    logic [2:0]        cfg_perm;
    logic              req_valid;
    logic              req_ready;
    logic [VA_W-1:0]   req_vaddr;
    logic [1:0]        req_kind;
    logic              rsp_valid;
    logic [BASE_W-1:0] rsp_paddr;
    logic [1:0]        rsp_fault;

    int total = 0;
    int bad   = 0;

    logic              m_valid [SEG_COUNT];
    logic [BASE_W-1:0] m_base  [SEG_COUNT];
    logic [LIM_W-1:0]  m_limit [SEG_COUNT];
    logic [2:0]        m_perm  [SEG_COUNT];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlat #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .BASE_W(BASE_W)) dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_perm(cfg_perm),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    // Expected {fault, paddr} from the requirements (R3..R7)
    function automatic logic [BASE_W+1:0] expect_rsp(input int seg,
                                                      input logic [OFF_W-1:0] off,
                                                      input logic [1:0] kind);
        logic ok;
        if (!m_valid[seg]) return {2'b11, {BASE_W{1'b0}}};
        if ({1'b0, off} >= m_limit[seg]) return {2'b01, {BASE_W{1'b0}}};
        ok = (kind == 2'b00) ? m_perm[seg][0] :
             (kind == 2'b01) ? m_perm[seg][1] :
             (kind == 2'b10) ? m_perm[seg][2] : 1'b0;
        if (!ok) return {2'b10, {BASE_W{1'b0}}};
        return {2'b00, m_base[seg] + BASE_W'(off)};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic v, input logic [BASE_W-1:0] base,
                             input logic [LIM_W-1:0] lim, input logic [2:0] perm);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = SEG_W'(idx); cfg_valid = v;
        cfg_base = base; cfg_limit = lim; cfg_perm = perm;
        @(negedge clk);
        cfg_we = 1'b0;
        m_valid[idx] = v; m_base[idx] = base; m_limit[idx] = lim; m_perm[idx] = perm;
    endtask

    task automatic lookup(input int seg, input logic [OFF_W-1:0] off,
                          input logic [1:0] kind, input string req);
        logic [BASE_W+1:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {SEG_W'(seg), off}; req_kind = kind;
        e = expect_rsp(seg, off, kind);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, {req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({rsp_fault, rsp_paddr} == e, req, 64'({rsp_fault, rsp_paddr}), 64'(e));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < SEG_COUNT; i++) begin
            m_valid[i] = 1'b0; m_base[i] = '0; m_limit[i] = '0; m_perm[i] = '0;
        end
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_base = '0;
        cfg_limit = '0; cfg_perm = '0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check(req_ready == 1'b0, "R1 ready in reset", 64'(req_ready), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        for (int s = 0; s < SEG_COUNT; s++) lookup(s, 16'h0000, 2'b01, "R1 R6 entry invalid after reset");

        // R3 R2: code and data segments
        cfg_write(0, 1'b1, 32'h0001_0000, 17'h01000, 3'b011);
        cfg_write(5, 1'b1, 32'h8000_0000, 17'h00100, 3'b110);
        lookup(0, 16'h0123, 2'b00, "R3 fetch code");
        lookup(0, 16'h0123, 2'b01, "R3 load code");
        lookup(5, 16'h00FF, 2'b10, "R2 R3 store data top byte");
        // R5 permission
        lookup(0, 16'h0010, 2'b10, "R5 store to code");
        lookup(5, 16'h0010, 2'b00, "R5 fetch from data");
        lookup(5, 16'h0010, 2'b11, "R5 reserved kind");
        // R4 bounds edges
        lookup(5, 16'h0100, 2'b01, "R4 offset equals limit");
        cfg_write(1, 1'b1, 32'h0000_4000, 17'h00000, 3'b111);
        lookup(1, 16'h0000, 2'b01, "R4 zero limit");
        cfg_write(2, 1'b1, 32'hFFFF_F000, 17'h10000, 3'b111);
        lookup(2, 16'hFFFF, 2'b01, "R4 R3 full limit with wrap");
        // R7 priority
        lookup(0, 16'h2000, 2'b10, "R7 bounds over permission");
        lookup(7, 16'hFFFF, 2'b11, "R7 invalid over all");
        // R10 invalidate
        cfg_write(0, 1'b0, 32'h0001_0000, 17'h01000, 3'b011);
        lookup(0, 16'h0001, 2'b00, "R10 invalidated entry");

        // R9 same-cycle write and lookup use old contents
        begin
            logic [BASE_W+1:0] e;
            @(negedge clk);
            cfg_we = 1'b1; cfg_idx = 3'd5; cfg_valid = 1'b1;
            cfg_base = 32'h1234_0000; cfg_limit = 17'h00010; cfg_perm = 3'b001;
            req_valid = 1'b1; req_vaddr = {3'd5, 16'h0020}; req_kind = 2'b10;
            e = expect_rsp(5, 16'h0020, 2'b10);
            @(negedge clk);
            cfg_we = 1'b0; req_valid = 1'b0;
            m_base[5] = 32'h1234_0000; m_limit[5] = 17'h00010; m_perm[5] = 3'b001;
            check({rsp_fault, rsp_paddr} == e, "R9 old contents", 64'({rsp_fault, rsp_paddr}), 64'(e));
            lookup(5, 16'h0020, 2'b10, "R9 new contents afterwards");
        end

        // R8 idle cycle after a response
        @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_fault == 2'b00 && rsp_paddr == '0,
              "R8 idle output", 64'({rsp_valid, rsp_fault, rsp_paddr}), 64'd0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int s;
            logic [OFF_W-1:0] off;
            s = int'($urandom_range(SEG_COUNT-1));
            if ($urandom_range(3) == 0)
                cfg_write(s, ($urandom_range(4) != 0), $urandom(),
                          LIM_W'($urandom_range(32'h10000)), 3'($urandom_range(7)));
            case ($urandom_range(2))
                0: off = OFF_W'(m_limit[s] - 1);
                1: off = OFF_W'(m_limit[s]);
                default: off = OFF_W'($urandom());
            endcase
            lookup(s, off, 2'($urandom_range(3)), "R3 R4 R5 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule